// File: doc/BRIEF.md
# Serial Audio Clock Monitor

This block supervises the bit clock and frame clock of a serial audio input from a faster, free-running reference clock. Both audio clocks are brought into the reference domain. On every rising frame-clock edge the block checks two things for the frame that just ended: how many bit-clock rising edges it contained, and how many reference cycles it lasted. A separate idle timer for each audio clock detects a clock that has stopped. Any of these faults raises `clk_err` and forces every output channel to high impedance.

The monitor only works while `play_en` is high. Dropping `play_en` clears the fault at once and disarms all measurement. Recovery needs no host action. Once two consecutive frames pass both checks with no stopped clock, `clk_err` falls and each channel goes back to whatever high-impedance state its own request input asks for. Latching the fault for software is the job of a downstream register.

All pins are plain level signals. The block has no data stream, so it has no valid/ready pair and applies no back-pressure.

Top module: `audclk_monitor`

## Requirements
- R1: While `play_en` is low, `clk_err` stays 0 whatever the audio clocks do. Lowering `play_en` during a fault clears `clk_err` on the next reference edge.
- R2: A frame, measured from one frame-clock rising edge to the next, must contain exactly 32, 64, 128 or 256 bit-clock rising edges. Any other count raises `clk_err` when that frame ends.
- R3: A frame's length in reference cycles must lie in [N−M, N+M] for at least one rate fs in {32000, 44100, 48000, 88200, 96000} Hz. Here N = floor(REF_HZ/fs) and M = floor(N·TOL_PPT/1000). A frame outside every window raises `clk_err` when it ends.
- R4: If either audio clock shows no edge for `halt_cycles` reference cycles, `clk_err` rises without waiting for a frame to end.
- R5: An edge-free gap shorter than `halt_cycles` is not a halt. The frame that contains the gap is still judged by R2 and R3.
- R6: The first frame-clock rising edge after `play_en` rises, or after a halt, only starts a measurement and is never judged.
- R7: While `clk_err` is 1, every bit of `chan_hiz` is 1.
- R8: In a fault, `clk_err` falls after the second consecutive frame that passes R2 and R3 with no halt. Any bad frame or halt restarts that count. Without a fault, `chan_hiz` equals `chan_hiz_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock, faster than twice the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| play_en | input | 1 | High while the device is in play mode; arms monitoring |
| bclk_in | input | 1 | Audio bit clock, asynchronous |
| fclk_in | input | 1 | Audio frame clock, asynchronous, changes on bit-clock falling edges |
| halt_cycles | input | HALT_W | Edge-free reference cycles that declare a clock stopped |
| chan_hiz_req | input | NCH | Per-channel high-impedance request from normal control |
| clk_err | output | 1 | Clock fault present |
| chan_hiz | output | NCH | Per-channel high-impedance command to the output stage |

## Verification
A wrong good-frame count or a stale primed flag appears at the ports as a release that comes one frame too early or too late. The bench samples half a frame either side of the expected edge to catch this. A measurement counter that is not cleared at arming or after a halt turns a legal format into a spurious `clk_err` within one frame. An idle timer that restarts on the wrong edge shifts halt detection by up to half a frame, which the samples taken before and after the timeout expose. Every change of `clk_err` is matched in order against the transitions the stimulus is expected to cause, so an extra or missing fault shows up at the next change.

// File: rtl/audclk_mon_pkg.sv
package audclk_mon_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FAULT = 2'd2
  } mon_state_e;

  localparam int unsigned NUM_RATES = 5;

  function automatic longint unsigned std_rate_hz(input int unsigned idx);
    case (idx)
      0:       return 64'd32000;
      1:       return 64'd44100;
      2:       return 64'd48000;
      3:       return 64'd88200;
      default: return 64'd96000;
    endcase
  endfunction

  function automatic longint unsigned win_margin(input longint unsigned nom,
                                                 input int unsigned tol_ppt);
    return (nom * tol_ppt) / 1000;
  endfunction

endpackage

// File: rtl/audclk_edge_sync.sv
module audclk_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic edge_any,
  output logic edge_rise
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], async_in};
  end

  assign edge_rise = pipe[STAGES-1] & ~pipe[STAGES];
  assign edge_any  = pipe[STAGES-1] ^ pipe[STAGES];
endmodule

// File: rtl/audclk_halt_timer.sv
module audclk_halt_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             edge_seen,
  input  logic [CNT_W-1:0] limit,
  output logic             halted
);
  logic [CNT_W-1:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 idle_cnt <= '0;
    else if (!arm || edge_seen) idle_cnt <= '0;
    else if (idle_cnt < limit)  idle_cnt <= idle_cnt + 1'b1;
  end

  // an edge in this very cycle ends the halt at once
  assign halted = arm && !edge_seen && (idle_cnt >= limit);
endmodule

// File: rtl/audclk_frame_meter.sv
module audclk_frame_meter
  import audclk_mon_pkg::*;
#(
  parameter longint unsigned REF_HZ         = 49_152_000,
  parameter int unsigned     TOL_PPT        = 20,
  parameter int unsigned     MIN_RATIO_LOG2 = 5,
  parameter int unsigned     NUM_RATIOS     = 4,
  parameter int unsigned     REF_CNT_W      = 13,
  parameter int unsigned     BCK_CNT_W      = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic restart,
  input  logic bck_rise,
  input  logic fck_rise,
  output logic frame_done,
  output logic ratio_ok,
  output logic rate_ok
);
  logic [REF_CNT_W-1:0]  ref_cnt;
  logic [BCK_CNT_W-1:0]  bck_cnt;
  logic                  primed;
  logic [NUM_RATES-1:0]  rate_hit;
  logic [NUM_RATIOS-1:0] ratio_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt <= '0;
      bck_cnt <= '0;
      primed  <= 1'b0;
    end else if (!arm || restart) begin
      ref_cnt <= '0;
      bck_cnt <= '0;
      primed  <= 1'b0;
    end else if (fck_rise) begin
      ref_cnt <= REF_CNT_W'(1);
      bck_cnt <= bck_rise ? BCK_CNT_W'(1) : '0;
      primed  <= 1'b1;
    end else begin
      if (!(&ref_cnt))           ref_cnt <= ref_cnt + 1'b1;
      if (bck_rise && !(&bck_cnt)) bck_cnt <= bck_cnt + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
    localparam longint unsigned NOM  = REF_HZ / std_rate_hz(g);
    localparam longint unsigned MARG = win_margin(NOM, TOL_PPT);
    localparam longint unsigned LO   = NOM - MARG;
    localparam longint unsigned HI   = NOM + MARG;
    assign rate_hit[g] = (ref_cnt >= REF_CNT_W'(LO)) && (ref_cnt <= REF_CNT_W'(HI));
  end

  for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_ratio
    localparam longint unsigned RATIO = 64'd1 << (MIN_RATIO_LOG2 + g);
    assign ratio_hit[g] = (bck_cnt == BCK_CNT_W'(RATIO));
  end

  assign frame_done = arm && !restart && fck_rise && primed;
  assign ratio_ok   = |ratio_hit;
  assign rate_ok    = |rate_hit;
endmodule

// File: rtl/audclk_monitor.sv
module audclk_monitor
  import audclk_mon_pkg::*;
#(
  parameter longint unsigned REF_HZ         = 49_152_000,
  parameter int unsigned     TOL_PPT        = 20,
  parameter int unsigned     NCH            = 2,
  parameter int unsigned     HALT_W         = 16,
  parameter int unsigned     SYNC_STAGES    = 2,
  parameter int unsigned     MIN_RATIO_LOG2 = 5,
  parameter int unsigned     NUM_RATIOS     = 4,
  parameter int unsigned     RELEASE_FRAMES = 2
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              play_en,
  input  logic              bclk_in,
  input  logic              fclk_in,
  input  logic [HALT_W-1:0] halt_cycles,
  input  logic [NCH-1:0]    chan_hiz_req,
  output logic              clk_err,
  output logic [NCH-1:0]    chan_hiz
);
  localparam longint unsigned MAX_FRAME = (REF_HZ / 32000) * 2;
  localparam int unsigned REF_CNT_W = $clog2(MAX_FRAME + 1);
  localparam int unsigned BCK_CNT_W = MIN_RATIO_LOG2 + NUM_RATIOS + 1;
  localparam int unsigned GOOD_W    = $clog2(RELEASE_FRAMES + 1);

  // index 0: bit clock, index 1: frame clock
  logic [1:0] raw_clk, edge_any, edge_rise, halted;
  logic       any_halt, frame_done, ratio_ok, rate_ok, frame_good, trip;
  mon_state_e state, state_d;
  logic [GOOD_W-1:0] good_cnt, good_d;

  assign raw_clk = {fclk_in, bclk_in};

  for (genvar g = 0; g < 2; g++) begin : g_clk
    audclk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk_ref),
      .rst_n    (rst_n),
      .async_in (raw_clk[g]),
      .edge_any (edge_any[g]),
      .edge_rise(edge_rise[g])
    );
    audclk_halt_timer #(.CNT_W(HALT_W)) u_halt (
      .clk      (clk_ref),
      .rst_n    (rst_n),
      .arm      (play_en),
      .edge_seen(edge_any[g]),
      .limit    (halt_cycles),
      .halted   (halted[g])
    );
  end

  assign any_halt = |halted;

  audclk_frame_meter #(
    .REF_HZ        (REF_HZ),
    .TOL_PPT       (TOL_PPT),
    .MIN_RATIO_LOG2(MIN_RATIO_LOG2),
    .NUM_RATIOS    (NUM_RATIOS),
    .REF_CNT_W     (REF_CNT_W),
    .BCK_CNT_W     (BCK_CNT_W)
  ) u_meter (
    .clk       (clk_ref),
    .rst_n     (rst_n),
    .arm       (play_en),
    .restart   (any_halt),
    .bck_rise  (edge_rise[0]),
    .fck_rise  (edge_rise[1]),
    .frame_done(frame_done),
    .ratio_ok  (ratio_ok),
    .rate_ok   (rate_ok)
  );

  assign frame_good = ratio_ok && rate_ok;
  assign trip       = any_halt || (frame_done && !frame_good);

  always_comb begin
    state_d = state;
    good_d  = good_cnt;
    if (!play_en) begin
      state_d = ST_IDLE;
      good_d  = '0;
    end else begin
      case (state)
        ST_IDLE: state_d = ST_RUN;
        ST_RUN: begin
          if (trip) begin
            state_d = ST_FAULT;
            good_d  = '0;
          end
        end
        ST_FAULT: begin
          if (trip) begin
            good_d = '0;
          end else if (frame_done) begin
            if (good_cnt == GOOD_W'(RELEASE_FRAMES - 1)) begin
              state_d = ST_RUN;
              good_d  = '0;
            end else begin
              good_d = good_cnt + 1'b1;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      good_cnt <= '0;
    end else begin
      state    <= state_d;
      good_cnt <= good_d;
    end
  end

  assign clk_err  = (state == ST_FAULT);
  assign chan_hiz = chan_hiz_req | {NCH{clk_err}};
endmodule

// File: rtl/audclk_monitor_chk.sv
module audclk_monitor_chk #(
  parameter int unsigned NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           play_en,
  input logic           clk_err,
  input logic [NCH-1:0] chan_hiz,
  input logic [NCH-1:0] chan_hiz_req,
  input logic           any_halt,
  input logic           frame_done,
  input logic           frame_good
);
  assert_arm_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !play_en |=> !clk_err);

  // R2, R3 and R4: a halt or a failed frame in play mode enters the fault
  assert_trip_enters_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (play_en && $past(play_en) && (any_halt || (frame_done && !frame_good))) |=> clk_err);

  assert_rise_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_err) |-> $past(any_halt || (frame_done && !frame_good)));

  assert_all_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clk_err |-> (&chan_hiz));

  assert_fall_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_err) |-> $past(!play_en || (frame_done && frame_good)));

  assert_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_err |-> (chan_hiz == chan_hiz_req));
endmodule

bind audclk_monitor audclk_monitor_chk #(.NCH(NCH)) u_chk (
  .clk         (clk_ref),
  .rst_n       (rst_n),
  .play_en     (play_en),
  .clk_err     (clk_err),
  .chan_hiz    (chan_hiz),
  .chan_hiz_req(chan_hiz_req),
  .any_halt    (any_halt),
  .frame_done  (frame_done),
  .frame_good  (frame_good)
);

// File: tb/audclk_monitor_tb_top.sv
`timescale 1ns/1ps
module audclk_monitor_tb_top;
  localparam int F = 512; // 48 kHz frame at the bench reference rate

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        play_en = 1'b0;
  logic        bclk = 1'b0;
  logic        fclk = 1'b0;
  logic [15:0] halt_cycles = 16'd600;
  logic [1:0]  hiz_req = 2'b00;
  logic        clk_err;
  logic [1:0]  chan_hiz;

  always #2.5 clk = ~clk;

  audclk_monitor #(.REF_HZ(24_576_000), .TOL_PPT(25)) dut_i (
    .clk_ref(clk), .rst_n(rst_n), .play_en(play_en),
    .bclk_in(bclk), .fclk_in(fclk), .halt_cycles(halt_cycles),
    .chan_hiz_req(hiz_req), .clk_err(clk_err), .chan_hiz(chan_hiz)
  );

  int total = 0;
  int bad = 0;
  bit exp_q[$];

  // ---------------- clock pattern generator ----------------
  int  cur_ratio = 64, cur_half = 4, cur_pad = 0;
  bit  cur_frz = 1'b0;
  int  pend_ratio = 64, pend_half = 4, pend_pad = 0;
  bit  pend_frz = 1'b0;
  int  ph = 0, bidx = 0, padleft = 0;
  bit  gen_run = 1'b1;
  bit  bnd;
  event bound_ev;

  always @(negedge clk) begin
    if (gen_run) begin
      bnd = 1'b0;
      if (padleft > 0) begin
        padleft--;
        if (padleft == 0) bnd = 1'b1;
      end else begin
        ph++;
        if (ph >= cur_half) begin
          ph = 0;
          bclk = ~bclk;
          if (!bclk) begin
            bidx++;
            if (bidx >= cur_ratio) begin
              bidx = 0;
              if (cur_pad > 0) padleft = cur_pad;
              else bnd = 1'b1;
            end else if (bidx == cur_ratio / 2 && !cur_frz) begin
              fclk = 1'b0;
            end
          end
        end
      end
      if (bnd) begin
        cur_ratio = pend_ratio; cur_half = pend_half;
        cur_pad = pend_pad; cur_frz = pend_frz;
        if (!cur_frz) fclk = 1'b1;
        -> bound_ev;
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_err(input string req, input bit e);
    chk(clk_err === e, req, "clk_err", int'(clk_err), int'(e));
  endtask

  task automatic check_hiz(input string req, input logic [1:0] e);
    chk(chan_hiz === e, req, "chan_hiz", int'(chan_hiz), int'(e));
  endtask

  task automatic set_fmt(input int r, input int h, input int p);
    pend_ratio = r; pend_half = h; pend_pad = p;
    @(bound_ev);
  endtask

  task automatic push_exp(input bit v);
    exp_q.push_back(v);
  endtask

  // bad frame format, then back to 48k/64: fault, hold, release
  task automatic fault_cycle(input string req, input int r, input int h, input int p);
    push_exp(1'b1); push_exp(1'b0);
    set_fmt(r, h, p);
    set_fmt(64, 4, 0);
    step(F / 2);
    check_err(req, 1'b1);
    check_hiz("R7", 2'b11);
    step(F);
    check_err("R8", 1'b1);
    step(F);
    check_err("R8", 1'b0);
    check_hiz("R8", hiz_req);
  endtask

  // ---------------- scoreboard monitor ----------------
  logic last_err = 1'b0;
  always @(negedge clk) begin
    if (rst_n && clk_err !== last_err) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R8 unexpected clk_err change: actual=%0d expected=%0d",
                 int'(clk_err), int'(last_err));
      end else begin
        bit e;
        e = exp_q.pop_front();
        if (clk_err !== e) begin
          bad++;
          $display("FAIL R8 clk_err transition: actual=%0d expected=%0d",
                   int'(clk_err), int'(e));
        end
      end
      last_err = clk_err;
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    step(10);
    rst_n = 1'b1;
    step(2);
    check_err("R1", 1'b0);
    check_hiz("R8", 2'b00);

    // R1: illegal ratio while not in play mode
    set_fmt(36, 7, 0);
    repeat (4) @(bound_ev);
    step(10);
    check_err("R1", 1'b0);

    // R6: arm in mid-frame with a legal format
    set_fmt(64, 4, 0);
    step(2 * F + 137);
    play_en = 1'b1;
    step(4 * F);
    check_err("R6", 1'b0);

    // R2/R3: legal formats
    set_fmt(32, 4, 0);
    step(4 * 256);
    check_err("R2", 1'b0);
    set_fmt(64, 6, 0);
    step(4 * 768);
    check_err("R3", 1'b0);
    set_fmt(128, 2, 0);
    step(4 * F);
    check_err("R2", 1'b0);
    set_fmt(64, 4, 12);
    step(3 * 524);
    check_err("R3", 1'b0);
    set_fmt(64, 4, 0);

    // R3: one cycle past the window, R2: bad ratio, R3: unsupported rate
    fault_cycle("R3", 64, 4, 13);
    hiz_req = 2'b01;
    step(4);
    check_hiz("R8", 2'b01);
    fault_cycle("R2", 36, 7, 0);
    fault_cycle("R3", 64, 3, 0);

    // R8: a bad frame during recovery restarts the count
    push_exp(1'b1); push_exp(1'b0);
    set_fmt(36, 7, 0);
    set_fmt(64, 4, 0);
    set_fmt(36, 7, 0);
    set_fmt(64, 4, 0);
    step(F / 2);
    check_err("R8", 1'b1);
    step(F);
    check_err("R8", 1'b1);
    step(F);
    check_err("R8", 1'b0);

    // R4: both clocks stop
    push_exp(1'b1); push_exp(1'b0);
    @(bound_ev);
    gen_run = 1'b0;
    step(300);
    check_err("R4", 1'b0);
    step(400);
    check_err("R4", 1'b1);
    check_hiz("R7", 2'b11);
    gen_run = 1'b1;
    step(2 * F + F / 2);
    check_err("R6", 1'b1);
    step(F);
    check_err("R6", 1'b0);

    // R4: frame clock alone stuck low
    push_exp(1'b1); push_exp(1'b0);
    pend_frz = 1'b1;
    @(bound_ev);
    step(150);
    check_err("R4", 1'b0);
    step(350);
    check_err("R4", 1'b1);
    pend_frz = 1'b0;
    @(bound_ev);
    step(F + F / 2);
    check_err("R8", 1'b1);
    step(F);
    check_err("R8", 1'b0);

    // R5: gap shorter than the limit, judged by frame length
    halt_cycles = 16'd2000;
    @(bound_ev);
    gen_run = 1'b0;
    step(1000);
    check_err("R5", 1'b0);
    push_exp(1'b1); push_exp(1'b0);
    gen_run = 1'b1;
    step(F + F / 2);
    check_err("R5", 1'b1);
    step(2 * F);
    check_err("R5", 1'b0);
    halt_cycles = 16'd600;

    // R1: leaving play mode clears a fault at once
    push_exp(1'b1); push_exp(1'b0);
    set_fmt(36, 7, 0);
    set_fmt(64, 4, 0);
    step(100);
    check_err("R2", 1'b1);
    play_en = 1'b0;
    step(2);
    check_err("R1", 1'b0);
    check_hiz("R1", 2'b01);
    step(F + 61);
    play_en = 1'b1;
    step(4 * F);
    check_err("R6", 1'b0);

    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R8 missing clk_err transitions: actual=%0d expected=%0d",
               exp_q.size(), 0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule